// File: doc/BRIEF.md
# Divisor Triple Search Engine

This block picks the three clock dividers of a voice-band converter's sample-rate generator. The caller gives the master-clock frequency and the wanted sample rate, both in hertz, together with two mode flags. The block computes the ideal divider product, which is the master clock divided by sixteen times the sample rate. It rounds that product to the nearest integer and then walks through candidate factorizations. The first triple that obeys every range and mode rule is reported.

The product is split into a first divider M (1 to 128), a second divider N (1 to 16) and a third divider P (1 to 8). P equal to 8 selects the coarse sampling path. Any smaller P selects the fine path, which only works when the master clock divided by P falls inside a fixed window. A turbo flag forbids P of 1. A filter-bypass flag forces M to be a multiple of four. If the rounded product cannot be factored legally, the engine tries nearby products, alternating below and above and moving outward, before it gives up. It reports the product it actually used, so the caller can work out the rate error.

All division is done by a sequential restoring divider, one quotient bit per cycle. The search is handled by a single finite-state machine that owns one divider for the rate and one for the factor test.

Top module: `dts_search`

## Requirements
- R1: While reset is asserted and after its release, busy_o, done_o and fail_o are 0, and m_o, n_o, p_o and prod_o are 0.
- R2: The base product is round-half-up of mclk_hz_i / (16 × fs_hz_i), that is floor((mclk + 8·fs) / (16·fs)).
- R3: Candidates are tried with P from 8 down to 1 and, for each P, N from 16 down to 1, with M = product / (N·P) by exact division. The first legal triple is reported. For example, 56 448 000 Hz at 8000 Hz gives M=21, N=7, P=3.
- R4: On done_o, 1 ≤ m_o ≤ 128, 1 ≤ n_o ≤ 16, 1 ≤ p_o ≤ 8, and prod_o equals m_o·n_o·p_o.
- R5: A triple with P below 8 is legal only if 10 000 000·P ≤ mclk ≤ 25 000 000·P.
- R6: When turbo_i was set at the accepted start, P = 1 is never reported.
- R7: When bypass_i was set at the accepted start, m_o is a multiple of 4.
- R8: If a product has no legal triple, the next product is tried in the order base, base−1, base+1, base−2, base+2, …, up to an offset of MAX_OFF (default 3). Any product below 1 or above 16384 is skipped.
- R9: If no candidate yields a legal triple, or fs_hz_i is 0 at start, fail_o pulses and m_o, n_o, p_o and prod_o are cleared to 0.
- R10: done_o and fail_o are single-cycle pulses that are never high together. busy_o is high from the edge after an accepted start (with a non-zero rate) until the edge that raises the pulse, where it drops.
- R11: A start_i arriving while busy_o is high is ignored, and the running search reports the result of its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a search (taken only when idle) |
| mclk_hz_i | input | MCLK_W | Master-clock frequency in Hz |
| fs_hz_i | input | FS_W | Target sample rate in Hz |
| turbo_i | input | 1 | Turbo mode: forbid P = 1 |
| bypass_i | input | 1 | Filter bypass: M must be a multiple of 4 |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse: legal triple found |
| fail_o | output | 1 | One-cycle pulse: no legal triple |
| m_o | output | 8 | First divider M |
| n_o | output | 5 | Second divider N |
| p_o | output | 4 | Third divider P (8 = coarse) |
| prod_o | output | 15 | Product M·N·P actually used |

## Verification
On every cycle, the bound checker enforces these properties of each reported triple:
- the divider ranges and the product identity;
- the fine-path clock window;
- the turbo and bypass restrictions against the request that was latched at start;
- the pulse shape and exclusivity of done and fail;
- the cleared outputs on failure;
- that a start during a search leaves the latched request unchanged.

Only the bench's scenarios can show other properties, because they need an independent model of the search:
- that the reported triple is the first one in the defined search order;
- that the rounding picks the right base;
- that the outward fallback reaches the right neighbouring product;
- that an ignored start does not change the answer.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int M_MAX    = 128;
  localparam int N_MAX    = 16;
  localparam int P_MAX    = 8;
  localparam int PROD_MAX = M_MAX * N_MAX * P_MAX;
  localparam int M_W      = $clog2(M_MAX + 1);
  localparam int N_W      = $clog2(N_MAX + 1);
  localparam int P_W      = $clog2(P_MAX + 1);
  localparam int NP_W     = $clog2(N_MAX * P_MAX + 1);
  localparam int PROD_W   = $clog2(PROD_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ABORT,
    ST_RATE,
    ST_CAND,
    ST_PAIR,
    ST_FACT
  } dts_state_e;
endpackage

// File: rtl/dts_seq_div.sv
// Restoring divider, one quotient bit per cycle.
module dts_seq_div #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [NUM_W-1:0] num_q, quo_q;
  logic [DEN_W-1:0] den_q, rem_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  always_comb begin
    trial = {rem_q, num_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    ge    = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      num_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        num_q <= num_i;
        den_q <= den_i;
        rem_q <= '0;
        quo_q <= '0;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], ge};
        num_q <= num_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/dts_cand_gen.sv
// Maps an offset index to base, base-1, base+1, base-2, ...
module dts_cand_gen
  import dts_pkg::*;
#(
  parameter int BASE_W  = 27,
  parameter int MAX_OFF = 3,
  localparam int K_W    = $clog2(2 * MAX_OFF + 1)
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [K_W-1:0]    k_i,
  output logic [PROD_W-1:0] cand_o,
  output logic              valid_o,
  output logic              last_o
);
  localparam int SW = BASE_W + 2;

  logic [K_W:0]          kp1, mag;
  logic signed [SW-1:0]  base_s, mag_s, sum_s;

  always_comb begin
    kp1    = {1'b0, k_i} + 1'b1;
    mag    = kp1 >> 1;
    base_s = $signed({2'b00, base_i});
    mag_s  = $signed({{(SW-K_W-1){1'b0}}, mag});
    sum_s  = k_i[0] ? (base_s - mag_s) : (base_s + mag_s);
    valid_o = (sum_s >= 1) && (sum_s <= PROD_MAX);
    cand_o  = sum_s[PROD_W-1:0];
    last_o  = (k_i == K_W'(2 * MAX_OFF));
  end
endmodule

// File: rtl/dts_rule_chk.sv
// Mode and range rules for one (N, P) pair and its exact-division result.
module dts_rule_chk
  import dts_pkg::*;
#(
  parameter int MCLK_W     = 27,
  parameter int FINE_LO_HZ = 10_000_000,
  parameter int FINE_HI_HZ = 25_000_000
) (
  input  logic [MCLK_W-1:0] mclk_i,
  input  logic [PROD_W-1:0] cand_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [P_W-1:0]    p_i,
  input  logic              turbo_i,
  input  logic              bypass_i,
  input  logic [PROD_W-1:0] quo_i,
  input  logic [NP_W-1:0]   rem_i,
  output logic [NP_W-1:0]   np_o,
  output logic              pre_ok_o,
  output logic              fit_ok_o
);
  localparam int WIN_W = 40;

  logic [NP_W-1:0]   np;
  logic [PROD_W-1:0] np_w, m_lim;
  logic [WIN_W-1:0]  lo_hz, hi_hz, mclk_w;
  logic              coarse, win_ok, turbo_ok;

  always_comb begin
    np       = NP_W'(n_i) * NP_W'(p_i);
    np_w     = PROD_W'(np);
    m_lim    = PROD_W'(M_MAX) * np_w;
    lo_hz    = WIN_W'(FINE_LO_HZ) * WIN_W'(p_i);
    hi_hz    = WIN_W'(FINE_HI_HZ) * WIN_W'(p_i);
    mclk_w   = WIN_W'(mclk_i);
    coarse   = (p_i == P_W'(P_MAX));
    win_ok   = coarse || ((mclk_w >= lo_hz) && (mclk_w <= hi_hz));
    turbo_ok = !(turbo_i && (p_i == P_W'(1)));
    pre_ok_o = win_ok && turbo_ok && (cand_i >= np_w) && (cand_i <= m_lim);
    fit_ok_o = (rem_i == '0) && (quo_i != '0) && (quo_i <= PROD_W'(M_MAX)) &&
               (!bypass_i || (quo_i[1:0] == 2'b00));
    np_o     = np;
  end
endmodule

// File: rtl/dts_search.sv
module dts_search
  import dts_pkg::*;
#(
  parameter int MCLK_W     = 27,
  parameter int FS_W       = 16,
  parameter int MAX_OFF    = 3,
  parameter int FINE_LO_HZ = 10_000_000,
  parameter int FINE_HI_HZ = 25_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MCLK_W-1:0] mclk_hz_i,
  input  logic [FS_W-1:0]   fs_hz_i,
  input  logic              turbo_i,
  input  logic              bypass_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [P_W-1:0]    p_o,
  output logic [PROD_W-1:0] prod_o
);
  localparam int DEN_W = FS_W + 4;
  localparam int K_W   = $clog2(2 * MAX_OFF + 1);

  dts_state_e        st_q;
  logic [MCLK_W-1:0] mclk_q, base_q;
  logic [DEN_W-1:0]  fs16_q;
  logic              turbo_q, byp_q;
  logic [K_W-1:0]    k_q;
  logic [PROD_W-1:0] cand_q;
  logic [N_W-1:0]    n_q;
  logic [P_W-1:0]    p_q;
  logic              done_q, fail_q;
  logic [M_W-1:0]    m_res_q;
  logic [N_W-1:0]    n_res_q;
  logic [P_W-1:0]    p_res_q;
  logic [PROD_W-1:0] prod_res_q;

  // rate divider
  logic              rd_start, rd_done;
  logic [MCLK_W-1:0] rd_quo;
  logic [DEN_W-1:0]  rd_rem;
  logic              round_up;

  assign rd_start = (st_q == ST_IDLE) && start_i && (fs_hz_i != '0);
  assign round_up = {rd_rem, 1'b0} >= {1'b0, fs16_q};

  dts_seq_div #(.NUM_W(MCLK_W), .DEN_W(DEN_W)) u_rate_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rd_start),
    .num_i  (mclk_hz_i),
    .den_i  ({fs_hz_i, 4'b0000}),
    .done_o (rd_done),
    .quo_o  (rd_quo),
    .rem_o  (rd_rem)
  );

  // candidate product
  logic [PROD_W-1:0] cand;
  logic              cand_valid, cand_last;

  dts_cand_gen #(.BASE_W(MCLK_W), .MAX_OFF(MAX_OFF)) u_cand (
    .base_i (base_q),
    .k_i    (k_q),
    .cand_o (cand),
    .valid_o(cand_valid),
    .last_o (cand_last)
  );

  // factor test
  logic [NP_W-1:0]   np;
  logic              pre_ok, fit_ok, fd_start, fd_done;
  logic [PROD_W-1:0] fd_quo;
  logic [NP_W-1:0]   fd_rem;

  dts_rule_chk #(
    .MCLK_W    (MCLK_W),
    .FINE_LO_HZ(FINE_LO_HZ),
    .FINE_HI_HZ(FINE_HI_HZ)
  ) u_rule (
    .mclk_i  (mclk_q),
    .cand_i  (cand_q),
    .n_i     (n_q),
    .p_i     (p_q),
    .turbo_i (turbo_q),
    .bypass_i(byp_q),
    .quo_i   (fd_quo),
    .rem_i   (fd_rem),
    .np_o    (np),
    .pre_ok_o(pre_ok),
    .fit_ok_o(fit_ok)
  );

  assign fd_start = (st_q == ST_PAIR) && pre_ok;

  dts_seq_div #(.NUM_W(PROD_W), .DEN_W(NP_W)) u_fact_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(fd_start),
    .num_i  (cand_q),
    .den_i  (np),
    .done_o (fd_done),
    .quo_o  (fd_quo),
    .rem_o  (fd_rem)
  );

  // next-pair stepping: N descends inside P, P descends inside the candidate
  logic pair_wrap, cand_wrap;
  assign pair_wrap = (n_q == N_W'(1));
  assign cand_wrap = pair_wrap && (p_q == P_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mclk_q     <= '0;
      fs16_q     <= '0;
      turbo_q    <= 1'b0;
      byp_q      <= 1'b0;
      base_q     <= '0;
      k_q        <= '0;
      cand_q     <= '0;
      n_q        <= '0;
      p_q        <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      m_res_q    <= '0;
      n_res_q    <= '0;
      p_res_q    <= '0;
      prod_res_q <= '0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            mclk_q  <= mclk_hz_i;
            fs16_q  <= {fs_hz_i, 4'b0000};
            turbo_q <= turbo_i;
            byp_q   <= bypass_i;
            st_q    <= (fs_hz_i == '0) ? ST_ABORT : ST_RATE;
          end
        end
        ST_ABORT: begin
          fail_q     <= 1'b1;
          m_res_q    <= '0;
          n_res_q    <= '0;
          p_res_q    <= '0;
          prod_res_q <= '0;
          st_q       <= ST_IDLE;
        end
        ST_RATE: begin
          if (rd_done) begin
            base_q <= rd_quo + MCLK_W'(round_up);
            k_q    <= '0;
            st_q   <= ST_CAND;
          end
        end
        ST_CAND: begin
          if (cand_valid) begin
            cand_q <= cand;
            n_q    <= N_W'(N_MAX);
            p_q    <= P_W'(P_MAX);
            st_q   <= ST_PAIR;
          end else if (cand_last) begin
            st_q <= ST_ABORT;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        ST_PAIR, ST_FACT: begin
          if (st_q == ST_PAIR && pre_ok) begin
            st_q <= ST_FACT;
          end else if (st_q == ST_FACT && !fd_done) begin
            st_q <= ST_FACT;
          end else if (st_q == ST_FACT && fit_ok) begin
            done_q     <= 1'b1;
            m_res_q    <= M_W'(fd_quo);
            n_res_q    <= n_q;
            p_res_q    <= p_q;
            prod_res_q <= cand_q;
            st_q       <= ST_IDLE;
          end else if (cand_wrap) begin
            if (cand_last) begin
              st_q <= ST_ABORT;
            end else begin
              k_q  <= k_q + 1'b1;
              st_q <= ST_CAND;
            end
          end else if (pair_wrap) begin
            p_q  <= p_q - 1'b1;
            n_q  <= N_W'(N_MAX);
            st_q <= ST_PAIR;
          end else begin
            n_q  <= n_q - 1'b1;
            st_q <= ST_PAIR;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;
  assign m_o    = m_res_q;
  assign n_o    = n_res_q;
  assign p_o    = p_res_q;
  assign prod_o = prod_res_q;
endmodule

// File: rtl/dts_search_chk.sv
module dts_search_chk
  import dts_pkg::*;
#(
  parameter int MCLK_W     = 27,
  parameter int FINE_LO_HZ = 10_000_000,
  parameter int FINE_HI_HZ = 25_000_000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [M_W-1:0]    m_o,
  input logic [N_W-1:0]    n_o,
  input logic [P_W-1:0]    p_o,
  input logic [PROD_W-1:0] prod_o,
  input logic [MCLK_W-1:0] mclk_q,
  input logic              turbo_q,
  input logic              byp_q
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_FAIL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o); // R10
  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o)); // R10
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> !busy_o); // R10
  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (m_o >= 1 && m_o <= M_W'(M_MAX) && n_o >= 1 && n_o <= N_W'(N_MAX) &&
                p_o >= 1 && p_o <= P_W'(P_MAX))); // R4
  AST_PROD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (32'(prod_o) == 32'(m_o) * 32'(n_o) * 32'(p_o))); // R4
  AST_FINE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && p_o != P_W'(P_MAX)) |->
      (64'(mclk_q) >= 64'(FINE_LO_HZ) * 64'(p_o) &&
       64'(mclk_q) <= 64'(FINE_HI_HZ) * 64'(p_o))); // R5
  AST_TURBO_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && turbo_q) |-> (p_o != P_W'(1))); // R6
  AST_BYPASS_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && byp_q) |-> (m_o[1:0] == 2'b00)); // R7
  AST_FAIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (m_o == '0 && n_o == '0 && p_o == '0 && prod_o == '0)); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mclk_q)); // R11
endmodule

bind dts_search dts_search_chk #(
  .MCLK_W    (MCLK_W),
  .FINE_LO_HZ(FINE_LO_HZ),
  .FINE_HI_HZ(FINE_HI_HZ)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .fail_o (fail_o),
  .m_o    (m_o),
  .n_o    (n_o),
  .p_o    (p_o),
  .prod_o (prod_o),
  .mclk_q (mclk_q),
  .turbo_q(turbo_q),
  .byp_q  (byp_q)
);

// File: tb/tb_dts_search.sv
`timescale 1ns/1ps
module tb_dts_search;
  localparam int MAX_OFF = 3;
  localparam int WAIT_MAX = 60000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [26:0] mclk = '0;
  logic [15:0] fs = '0;
  logic        turbo = 1'b0;
  logic        byp = 1'b0;
  logic        busy_o, done_o, fail_o;
  logic [7:0]  m_o;
  logic [4:0]  n_o;
  logic [3:0]  p_o;
  logic [14:0] prod_o;

  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  dts_search dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .mclk_hz_i(mclk),
    .fs_hz_i  (fs),
    .turbo_i  (turbo),
    .bypass_i (byp),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fail_o   (fail_o),
    .m_o      (m_o),
    .n_o      (n_o),
    .p_o      (p_o),
    .prod_o   (prod_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Independent search model built from the requirements.
  function automatic bit model(input longint mc, input longint f, input bit tu,
                               input bit bp, output int em, output int en,
                               output int ep, output int eprod);
    longint base, c;
    em = 0; en = 0; ep = 0; eprod = 0;
    if (f == 0) return 1'b0;
    base = (mc + 8 * f) / (16 * f);
    for (int k = 0; k <= 2 * MAX_OFF; k++) begin
      c = (k % 2 == 1) ? base - (k + 1) / 2 : base + (k + 1) / 2;
      if (c < 1 || c > 16384) continue;
      for (int p = 8; p >= 1; p--) begin
        if (tu && p == 1) continue;
        if (p != 8 && (mc < 64'd10_000_000 * p || mc > 64'd25_000_000 * p)) continue;
        for (int n = 16; n >= 1; n--) begin
          longint m;
          if (c % (n * p) != 0) continue;
          m = c / (n * p);
          if (m < 1 || m > 128) continue;
          if (bp && (m % 4) != 0) continue;
          em = int'(m); en = n; ep = p; eprod = int'(c);
          return 1'b1;
        end
      end
    end
    return 1'b0;
  endfunction

  task automatic run_case(input longint mc, input longint f, input bit tu, input bit bp,
                          input string req, input bit inject);
    int  em, en, ep, eprod, w;
    bit  eok;
    longint act_t, exp_t;
    eok = model(mc, f, tu, bp, em, en, ep, eprod);
    @(negedge clk);
    mclk = mc[26:0]; fs = f[15:0]; turbo = tu; byp = bp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (f != 0) chk(busy_o == 1'b1, "R10", "busy after start", longint'(busy_o), 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      mclk = 27'd99_000_000; fs = 16'd7000; turbo = !tu; byp = !bp; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!(done_o || fail_o) && w < WAIT_MAX) begin
      @(negedge clk);
      w++;
    end
    if (w >= WAIT_MAX) begin
      chk(1'b0, req, "watchdog expired", longint'(w), 0);
    end else begin
      chk(done_o == eok && fail_o == !eok, req, "status done", longint'(done_o), longint'(eok));
      act_t = longint'(m_o) * 1000000 + longint'(n_o) * 1000 + longint'(p_o);
      exp_t = longint'(em) * 1000000 + longint'(en) * 1000 + longint'(ep);
      chk(act_t == exp_t, req, "M*1e6+N*1e3+P", act_t, exp_t);
      chk(longint'(prod_o) == longint'(eprod), req, "product", longint'(prod_o), longint'(eprod));
      @(negedge clk);
      chk(!done_o && !fail_o, "R10", "single-cycle pulse", longint'(done_o | fail_o), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy_o && !done_o && !fail_o && m_o == 0 && n_o == 0 && p_o == 0 && prod_o == 0,
        "R1", "outputs in reset", longint'(prod_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !fail_o && m_o == 0 && prod_o == 0,
        "R1", "outputs after reset", longint'(busy_o), 0);

    // R3 R5: worked example, fine window rejects P=7..4 style choices -> 21,7,3
    run_case(56_448_000, 8000, 1'b0, 1'b0, "R3", 1'b0);
    // R8: 220.5 rounds to 221 (no legal triple), fallback to 220 -> 4,11,5
    run_case(56_448_000, 16000, 1'b0, 1'b0, "R8", 1'b0);
    // R11: same request with a competing start mid-search
    run_case(56_448_000, 16000, 1'b0, 1'b0, "R11", 1'b1);
    // R2: 31.6 and 32.4 both round to 32 -> 1,4,8
    run_case(12_134_400, 24000, 1'b0, 1'b0, "R2", 1'b0);
    run_case(12_441_600, 24000, 1'b0, 1'b0, "R2", 1'b0);
    // R7: exact 32 with bypass -> 4,1,8
    run_case(12_288_000, 24000, 1'b0, 1'b1, "R7", 1'b0);
    // R5 R6: 125 at 20 MHz needs P=1; with turbo falls back to 124 -> 31,2,2
    run_case(20_000_000, 10000, 1'b0, 1'b0, "R5", 1'b0);
    run_case(20_000_000, 10000, 1'b1, 1'b0, "R6", 1'b0);
    // R9: zero rate and products beyond the legal range
    run_case(56_448_000, 0, 1'b0, 1'b0, "R9", 1'b0);
    run_case(100_000_000, 100, 1'b0, 1'b0, "R9", 1'b0);

    // R4 R3: constrained random requests
    for (int i = 0; i < 14; i++) begin
      longint mc, f;
      bit tu, bp;
      mc = longint'($urandom_range(100_000_000, 5_000_000));
      f  = longint'($urandom_range(26000, 4000));
      tu = 1'($urandom_range(1, 0));
      bp = 1'($urandom_range(1, 0));
      run_case(mc, f, tu, bp, "R4", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule